// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block holds the memory-population configuration of a controller with eight DRAM rows and turns it into per-row address ranges that other logic can use. Software or a sequencer writes an 8-bit cumulative boundary for each row, a 32-bit row-attribute word and a 32-bit controller-mode word over a simple valid/address/data bus. Every boundary value is the running total of memory up to and including its row, so the last row's value equals the total installed memory. The boundary unit is 32 MiB or 64 MiB.

From these registers the block derives, for every row, whether the row is populated, its first and last 4 KiB page, the width of its DRAM devices, and the ECC mode that applies to it. The ECC mode depends on whether data integrity is enabled, on the number of channels, and on the device width of the row. The block also answers a combinational lookup: a 4 KiB page number goes in, and the index of the row holding that page comes out, or a miss flag. Error-reporting logic typically uses this lookup to map a failing page address onto a row.

Top module: `row_map_decoder`

## Requirements
- R1: After reset every register holds zero, so all eight rows report unpopulated and any lookup reports a miss with row index 0.
- R2: A write with wr_valid high stores wr_data[7:0] into the boundary of row wr_addr for addresses 0 to 7, the whole word into the attribute register at address 8, and into the mode register at address 9. Any other address changes nothing. The decoded outputs and the lookup reflect a write in the cycle right after the clock edge that captured it.
- R3: The cumulative size of row i in pages is its boundary shifted left by 13 when the granularity field (mode bits 19:18) is zero, and shifted left by 14 when that field is nonzero.
- R4: A row is populated exactly when its cumulative size differs from that of the row below it. Row 0 is compared against zero.
- R5: A populated row starts at the cumulative size of the row below it (0 for row 0) and ends at its own cumulative size minus one. An unpopulated row reports a start and an end of 0.
- R6: Row i uses x4 devices when bit 4*i+3 of the attribute word is 1, and x8 devices when that bit is 0.
- R7: The 2-bit ECC mode of a row is 0 (none) when the integrity field (mode bits 21:20) is zero. Otherwise it is 2 (x4 symbol correction) when the channel bit (mode bit 22) is 1 and the row uses x4 devices, and 1 (single-error correct, double-error detect) in every other case.
- R8: When one or more populated rows hold the lookup page between their start and end inclusive, the lookup reports the lowest such row with the miss flag low.
- R9: When no populated row holds the lookup page, as with pages at or beyond the final boundary, the miss flag is high and the row index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 32 | Write data |
| lookup_page | input | 22 | 4 KiB page number to locate |
| row_populated | output | 8 | One bit per row, 1 when populated |
| row_start_page | output | 176 | First page of each row, 22 bits per row, row 0 lowest |
| row_end_page | output | 176 | Last page of each row, 22 bits per row, row 0 lowest |
| row_is_x4 | output | 8 | One bit per row, 1 for x4 devices |
| row_ecc_mode | output | 16 | ECC mode of each row, 2 bits per row, row 0 lowest |
| lookup_row | output | 3 | Index of the row holding lookup_page |
| lookup_miss | output | 1 | High when no populated row holds lookup_page |

## Verification
A corrupted boundary register or a wrong shift shows at once as a shifted start or end page on every row above the faulty one, and as a lookup that names the neighbouring row at the edge of a range. The stimulus therefore probes the first and last page of each populated range under both granularities, so an off-by-one or a wrong unit moves a result to another row within a single lookup. A wrong mode or attribute bit changes the ECC code or device width of specific rows in the cycle after the write, and writes to unmapped addresses are checked by watching that the whole row map stays the same.

// File: rtl/row_map_pkg.sv
package row_map_pkg;

    // Default geometry
    localparam int ROWS_DEF      = 8;
    localparam int BOUND_W_DEF   = 8;
    localparam int WORD_W_DEF    = 32;
    localparam int ADDR_W_DEF    = 4;

    // Boundary unit: 32 MiB expressed in 4 KiB pages is 2**13
    localparam int UNIT_SHIFT    = 13;

    // Register addresses above the boundary block
    localparam int ADDR_ATTR     = 8;
    localparam int ADDR_MODE     = 9;

    // Mode word fields
    localparam int MODE_CHAN_BIT = 22;
    localparam int MODE_INTEG_LO = 20;
    localparam int MODE_GRAN_LO  = 18;

    // Attribute word: one nibble per row, width flag at the top of it
    localparam int ATTR_STRIDE   = 4;
    localparam int ATTR_WIDTH_OF = 3;

    typedef enum logic [1:0] {
        ECC_NONE   = 2'd0,
        ECC_SECDED = 2'd1,
        ECC_X4SYM  = 2'd2
    } ecc_mode_e;

endpackage

// File: rtl/row_cfg_regs.sv
module row_cfg_regs
    import row_map_pkg::*;
#(
    parameter int NUM_ROWS = ROWS_DEF,
    parameter int BOUND_W  = BOUND_W_DEF,
    parameter int WORD_W   = WORD_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_valid,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [NUM_ROWS*BOUND_W-1:0] bound_o,
    output logic [WORD_W-1:0]           attr_o,
    output logic [WORD_W-1:0]           mode_o
);
    localparam int IDX_W = $clog2(NUM_ROWS);

    typedef struct packed {
        logic [NUM_ROWS-1:0][BOUND_W-1:0] bound;
        logic [WORD_W-1:0]                attr;
        logic [WORD_W-1:0]                mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_valid) begin
            if (int'(wr_addr) < NUM_ROWS) begin
                cfg_d.bound[wr_addr[IDX_W-1:0]] = wr_data[BOUND_W-1:0];
            end else if (int'(wr_addr) == ADDR_ATTR) begin
                cfg_d.attr = wr_data;
            end else if (int'(wr_addr) == ADDR_MODE) begin
                cfg_d.mode = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign bound_o = cfg_q.bound;
    assign attr_o  = cfg_q.attr;
    assign mode_o  = cfg_q.mode;

    // R2: a mode write lands in the mode register on the next edge
    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && int'(wr_addr) == ADDR_MODE) |=> (mode_o == $past(wr_data)));

    // R2: a boundary write lands in the addressed row
    assert_bound_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && int'(wr_addr) < NUM_ROWS)
        |=> (bound_o[$past(wr_addr[IDX_W-1:0])*BOUND_W +: BOUND_W] == $past(wr_data[BOUND_W-1:0])));

    // R2: unmapped addresses leave every register untouched
    assert_unmapped_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && int'(wr_addr) > ADDR_MODE)
        |=> ($stable(bound_o) && $stable(attr_o) && $stable(mode_o)));

endmodule

// File: rtl/row_range_decode.sv
module row_range_decode
    import row_map_pkg::*;
#(
    parameter int NUM_ROWS = ROWS_DEF,
    parameter int BOUND_W  = BOUND_W_DEF,
    parameter int WORD_W   = WORD_W_DEF,
    parameter int PAGE_W   = BOUND_W_DEF + UNIT_SHIFT + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_ROWS*BOUND_W-1:0] bound_i,
    input  logic [WORD_W-1:0]           attr_i,
    input  logic [WORD_W-1:0]           mode_i,
    output logic [NUM_ROWS-1:0]         populated_o,
    output logic [NUM_ROWS*PAGE_W-1:0]  start_o,
    output logic [NUM_ROWS*PAGE_W-1:0]  end_o,
    output logic [NUM_ROWS-1:0]         is_x4_o,
    output logic [NUM_ROWS*2-1:0]       ecc_o
);
    logic             gran_big;
    logic             dual_chan;
    logic             integ_on;
    logic [PAGE_W-1:0] cum  [NUM_ROWS];
    logic [PAGE_W-1:0] prev [NUM_ROWS];

    assign gran_big  = |mode_i[MODE_GRAN_LO +: 2];
    assign dual_chan = mode_i[MODE_CHAN_BIT];
    assign integ_on  = |mode_i[MODE_INTEG_LO +: 2];

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
        logic [PAGE_W-1:0] raw;
        logic              pop;
        logic              x4;
        ecc_mode_e         ecc;

        assign raw = PAGE_W'(bound_i[i*BOUND_W +: BOUND_W]);
        assign cum[i] = gran_big ? (raw << (UNIT_SHIFT + 1)) : (raw << UNIT_SHIFT);

        if (i == 0) begin : g_first
            assign prev[i] = '0;
        end else begin : g_rest
            assign prev[i] = cum[i-1];
        end

        assign pop = (cum[i] != prev[i]);
        assign x4  = attr_i[i*ATTR_STRIDE + ATTR_WIDTH_OF];

        always_comb begin
            if (!integ_on) begin
                ecc = ECC_NONE;
            end else if (dual_chan && x4) begin
                ecc = ECC_X4SYM;
            end else begin
                ecc = ECC_SECDED;
            end
        end

        assign populated_o[i]               = pop;
        assign start_o[i*PAGE_W +: PAGE_W]  = pop ? prev[i] : '0;
        assign end_o[i*PAGE_W +: PAGE_W]    = pop ? (cum[i] - PAGE_W'(1)) : '0;
        assign is_x4_o[i]                   = x4;
        assign ecc_o[i*2 +: 2]              = ecc;

        // R7: x4 symbol correction only on x4 rows of a dual-channel setup
        assert_x4sym_needs_x4_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ecc_o[i*2 +: 2] == ECC_X4SYM) |-> (is_x4_o[i] && mode_i[MODE_CHAN_BIT]));

        // R5: an unpopulated row reports an empty range
        assert_unpop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !populated_o[i] |-> (start_o[i*PAGE_W +: PAGE_W] == '0 && end_o[i*PAGE_W +: PAGE_W] == '0));
    end

endmodule

// File: rtl/row_page_lookup.sv
module row_page_lookup #(
    parameter int NUM_ROWS = 8,
    parameter int PAGE_W   = 22,
    parameter int IDX_W    = $clog2(NUM_ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_ROWS-1:0]        populated_i,
    input  logic [NUM_ROWS*PAGE_W-1:0] start_i,
    input  logic [NUM_ROWS*PAGE_W-1:0] end_i,
    input  logic [PAGE_W-1:0]          page_i,
    output logic [IDX_W-1:0]           row_o,
    output logic                       miss_o
);
    logic [NUM_ROWS-1:0] hit;

    for (genvar i = 0; i < NUM_ROWS; i++) begin : g_cmp
        assign hit[i] = populated_i[i]
                      && (page_i >= start_i[i*PAGE_W +: PAGE_W])
                      && (page_i <= end_i[i*PAGE_W +: PAGE_W]);
    end

    // Lowest matching row wins: scan from the top so the lowest index is kept
    always_comb begin
        row_o = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                row_o = IDX_W'(i);
            end
        end
        miss_o = ~|hit;
    end

    // R8: a reported hit always names a populated row
    assert_hit_populated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_o |-> populated_i[row_o]);

    // R9: a miss always reports row index zero
    assert_miss_row_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (row_o == '0));

endmodule

// File: rtl/row_map_decoder.sv
module row_map_decoder
    import row_map_pkg::*;
#(
    parameter int NUM_ROWS = ROWS_DEF,
    parameter int BOUND_W  = BOUND_W_DEF,
    parameter int WORD_W   = WORD_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int PAGE_W   = BOUND_W + UNIT_SHIFT + 1,
    parameter int IDX_W    = $clog2(NUM_ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic [PAGE_W-1:0]          lookup_page,
    output logic [NUM_ROWS-1:0]        row_populated,
    output logic [NUM_ROWS*PAGE_W-1:0] row_start_page,
    output logic [NUM_ROWS*PAGE_W-1:0] row_end_page,
    output logic [NUM_ROWS-1:0]        row_is_x4,
    output logic [NUM_ROWS*2-1:0]      row_ecc_mode,
    output logic [IDX_W-1:0]           lookup_row,
    output logic                       lookup_miss
);
    logic [NUM_ROWS*BOUND_W-1:0] bound_q;
    logic [WORD_W-1:0]           attr_q;
    logic [WORD_W-1:0]           mode_q;

    row_cfg_regs #(
        .NUM_ROWS (NUM_ROWS),
        .BOUND_W  (BOUND_W),
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .bound_o  (bound_q),
        .attr_o   (attr_q),
        .mode_o   (mode_q)
    );

    row_range_decode #(
        .NUM_ROWS (NUM_ROWS),
        .BOUND_W  (BOUND_W),
        .WORD_W   (WORD_W),
        .PAGE_W   (PAGE_W)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .bound_i     (bound_q),
        .attr_i      (attr_q),
        .mode_i      (mode_q),
        .populated_o (row_populated),
        .start_o     (row_start_page),
        .end_o       (row_end_page),
        .is_x4_o     (row_is_x4),
        .ecc_o       (row_ecc_mode)
    );

    row_page_lookup #(
        .NUM_ROWS (NUM_ROWS),
        .PAGE_W   (PAGE_W),
        .IDX_W    (IDX_W)
    ) u_lookup (
        .clk         (clk),
        .rst_n       (rst_n),
        .populated_i (row_populated),
        .start_i     (row_start_page),
        .end_i       (row_end_page),
        .page_i      (lookup_page),
        .row_o       (lookup_row),
        .miss_o      (lookup_miss)
    );

    // R8: the page of a hit lies inside the range the decoder reports for that row
    assert_hit_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_miss |-> (lookup_page >= row_start_page[lookup_row*PAGE_W +: PAGE_W]
                       && lookup_page <= row_end_page[lookup_row*PAGE_W +: PAGE_W]));

    // R7: with integrity off, no row carries an ECC mode
    assert_integ_off_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[MODE_INTEG_LO +: 2] == 2'b00) |-> (row_ecc_mode == '0));

endmodule

// File: tb/sim_row_map_decoder.sv
module sim_row_map_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NR   = 8;
    localparam int PW   = 22;
    localparam int NVEC = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [PW-1:0] lookup_page = '0;
    logic [NR-1:0]    row_populated;
    logic [NR*PW-1:0] row_start_page;
    logic [NR*PW-1:0] row_end_page;
    logic [NR-1:0]    row_is_x4;
    logic [NR*2-1:0]  row_ecc_mode;
    logic [2:0]       lookup_row;
    logic             lookup_miss;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    row_map_decoder u0 (
        .clk (clk), .rst_n (rst_n),
        .wr_valid (wr_valid), .wr_addr (wr_addr), .wr_data (wr_data),
        .lookup_page (lookup_page),
        .row_populated (row_populated), .row_start_page (row_start_page),
        .row_end_page (row_end_page), .row_is_x4 (row_is_x4),
        .row_ecc_mode (row_ecc_mode), .lookup_row (lookup_row),
        .lookup_miss (lookup_miss)
    );

    // {granularity big, page, expected row, expected miss}
    // Boundaries 2,2,5,5,5,8,9,9: rows 0,2,5,6 populated
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 22'd0,       3'd0, 1'b0},
        {1'b0, 22'd16383,   3'd0, 1'b0},
        {1'b0, 22'd16384,   3'd2, 1'b0},
        {1'b0, 22'd40959,   3'd2, 1'b0},
        {1'b0, 22'd40960,   3'd5, 1'b0},
        {1'b0, 22'd65535,   3'd5, 1'b0},
        {1'b0, 22'd65536,   3'd6, 1'b0},
        {1'b0, 22'd73727,   3'd6, 1'b0},
        {1'b0, 22'd73728,   3'd0, 1'b1},
        {1'b0, 22'd4194303, 3'd0, 1'b1},
        {1'b1, 22'd73728,   3'd2, 1'b0},
        {1'b1, 22'd131071,  3'd5, 1'b0},
        {1'b1, 22'd147455,  3'd6, 1'b0},
        {1'b1, 22'd147456,  3'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic look(input string req, input logic [PW-1:0] pg,
                        input logic [2:0] erow, input logic emiss);
        lookup_page = pg;
        #1;
        chk(req, {28'd0, lookup_miss, lookup_row}, {28'd0, emiss, erow});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic cur_gran;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 populated", {24'd0, row_populated}, 32'd0);
        look("R1 lookup", 22'd0, 3'd0, 1'b1);

        // Load boundaries
        wr(4'd0, 32'd2); wr(4'd1, 32'd2); wr(4'd2, 32'd5); wr(4'd3, 32'd5);
        wr(4'd4, 32'd5); wr(4'd5, 32'd8); wr(4'd6, 32'd9); wr(4'd7, 32'd9);

        // R4: populated map
        chk("R4 populated", {24'd0, row_populated}, 32'h65);
        // R5: ranges
        chk("R5 start r2", 32'(row_start_page[2*PW +: PW]), 32'd16384);
        chk("R5 end r2",   32'(row_end_page[2*PW +: PW]),   32'd40959);
        chk("R5 start r0", 32'(row_start_page[0 +: PW]),    32'd0);
        chk("R5 end r1 unpop", 32'(row_end_page[1*PW +: PW]), 32'd0);
        chk("R5 start r7 unpop", 32'(row_start_page[7*PW +: PW]), 32'd0);

        // R3 / R8 / R9 table walk
        cur_gran = 1'b0;
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][26] != cur_gran) begin
                cur_gran = VEC[k][26];
                wr(4'd9, cur_gran ? 32'h0004_0000 : 32'h0);
            end
            look(VEC[k][4] ? "R9 table" : (VEC[k][26] ? "R3 table" : "R8 table"),
                 VEC[k][25:4], VEC[k][3:1], VEC[k][0]);
        end

        // R3: upper granularity bit alone also selects the big unit
        wr(4'd9, 32'h0008_0000);
        look("R3 gran bit19", 22'd147455, 3'd6, 1'b0);
        chk("R3 end r6", 32'(row_end_page[6*PW +: PW]), 32'd147455);
        wr(4'd9, 32'h0);

        // R6: device width
        wr(4'd8, 32'h0800_0800);
        chk("R6 x4 map", {24'd0, row_is_x4}, 32'h44);

        // R7: ECC modes
        chk("R7 integ off", {16'd0, row_ecc_mode}, 32'd0);
        wr(4'd9, 32'h0060_0000);
        chk("R7 dual x4 r2", 32'(row_ecc_mode[4 +: 2]), 32'd2);
        chk("R7 dual x4 r6", 32'(row_ecc_mode[12 +: 2]), 32'd2);
        chk("R7 dual x8 r0", 32'(row_ecc_mode[0 +: 2]), 32'd1);
        wr(4'd9, 32'h0020_0000);
        chk("R7 single x4 r2", 32'(row_ecc_mode[4 +: 2]), 32'd1);
        wr(4'd9, 32'h0);

        // R2: unmapped address changes nothing
        wr(4'd13, 32'hFFFF_FFFF);
        chk("R2 unmapped pop", {24'd0, row_populated}, 32'h65);
        chk("R2 unmapped ecc", {16'd0, row_ecc_mode}, 32'd0);
        chk("R2 unmapped x4", {24'd0, row_is_x4}, 32'h44);
        look("R2 unmapped lookup", 22'd73728, 3'd0, 1'b1);

        // R2: write visible in the following cycle
        wr(4'd7, 32'd12);
        look("R2 new row7", 22'd73728, 3'd7, 1'b0);
        look("R9 past new end", 22'd98304, 3'd0, 1'b1);

        // R8: lowest row wins at shared boundary start after making row 1 populated
        wr(4'd1, 32'd3);
        look("R8 row1 now", 22'd16384, 3'd1, 1'b0);
        look("R8 row2 shrunk", 22'd24576, 3'd2, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule